// File: doc/BRIEF.md
# Destination Address Hash Filter

This block sits on the receive path of an Ethernet MAC and decides, from the destination address alone, whether the frame should be kept. Bytes of the destination field arrive one per clock while `byteValid` is high, with `frameStart` marking the first of them. Once the sixth byte has been taken, the filter registers a single-cycle decision that gives the accept verdict and the reasons behind it.

Four routes can admit a frame. The first is copy-all (promiscuous) mode. The second is an exact match against one station address. The third is a broadcast address, unless broadcast reception is switched off. The fourth is a hit in a 64-entry hash table. The hash index comes from a fixed fold: each of its six bits is the exclusive OR of every sixth address bit. The table bit it selects counts as a match only when the group bit of the address agrees with the enable for that address class. Software supplies the table, the station address and the mode bits as static inputs.

Top module: `addr_hash_filter`

## Requirements
- R1: While reset is asserted and after its release, `decisionValid` and `accept` are 0 until a destination field has been received.
- R2: Address bit 0 is the least significant bit of the first byte received and bit 47 is the most significant bit of the sixth. `decisionValid` rises for exactly one cycle, in the cycle after the sixth byte is taken.
- R3: `hashIndex` bit n equals the XOR of address bits n, n+6, n+12, ... n+42, for n from 0 to 5.
- R4: The 64-bit table is `{hashHi, hashLo}`. Index values 0 to 31 select bit i of `hashLo`, and values 32 to 63 select bit i-32 of `hashHi`.
- R5: A multicast hash hit needs `mcHashEn` = 1, address bit 0 = 1 and the selected table bit = 1. With every table bit set and `mcHashEn` on, every multicast address hits.
- R6: A unicast hash hit needs `ucHashEn` = 1, address bit 0 = 0 and the selected table bit = 1.
- R7: A set table bit gives no hit when the enable for the address's class is off, even if the other class's enable is on.
- R8: `exactHit` is 1 when the address equals the station address. `stationLo` holds bytes 0 to 3, with byte 0 in bits 7:0, and `stationHi` holds bytes 4 (bits 7:0) and 5 (bits 15:8).
- R9: The all-ones address sets `broadcastSeen` and is accepted when `noBroadcast` = 0. When `noBroadcast` = 1 it is rejected, even if the exact or hash path matches it.
- R10: With `copyAll` = 1 every frame is accepted, including a broadcast with `noBroadcast` = 1.
- R11: Once six bytes have been taken, further bytes are ignored until the next `frameStart`. A `frameStart` restarts the count at byte 0. Idle cycles between bytes (`byteValid` = 0) do not advance the count.
- R12: The mode bits, table and station address are sampled in the cycle the sixth byte is taken. Changes after that cycle do not alter the pending decision.
- R13: When `decisionValid` is 0, `accept`, `hashHit`, `exactHit`, `broadcastSeen` and `hashIndex` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | A destination byte is present on `byteIn` |
| frameStart | input | 1 | Marks the first destination byte of a frame |
| byteIn | input | 8 | Destination address byte |
| copyAll | input | 1 | Promiscuous mode: accept every frame |
| noBroadcast | input | 1 | Reject frames sent to the all-ones address |
| ucHashEn | input | 1 | Enable hash matching for individual addresses |
| mcHashEn | input | 1 | Enable hash matching for group addresses |
| hashLo | input | 32 | Hash table bits 31:0 |
| hashHi | input | 32 | Hash table bits 63:32 |
| stationLo | input | 32 | Station address bytes 0 to 3 |
| stationHi | input | 16 | Station address bytes 4 and 5 |
| decisionValid | output | 1 | One-cycle strobe: the decision fields are valid |
| accept | output | 1 | Frame passes the filter |
| hashIndex | output | 6 | Folded hash index of the address |
| hashHit | output | 1 | Hash table match for the address class |
| exactHit | output | 1 | Address equals the station address |
| broadcastSeen | output | 1 | Address is all ones |

## Verification
A byte counter that slips shows up at the ports as a decision strobe in the wrong cycle, a missing strobe, or an extra one. The scoreboard catches any of these on the first frame that is affected. A lane stored in the wrong byte position, or a wrong fold tap, changes `hashIndex` on the very next decision for most addresses, so the random frames expose it within a few frames. Faults in the priority between no-broadcast, copy-all and the match paths show only for broadcast or matching addresses, so the directed frames place those cases explicitly. The cycle after each decision also tests that a late configuration change has no effect on it.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = BYTE_W * ADDR_BYTES;
  localparam int HASH_BITS  = 6;
  localparam int HASH_SIZE  = 1 << HASH_BITS;
  localparam int HALF_W     = HASH_SIZE / 2;
  localparam int STA_LO_W   = 32;
  localparam int STA_HI_W   = ADDR_W - STA_LO_W;
  localparam int SEL_W      = $clog2(ADDR_BYTES + 1);

  // strobes from the byte sequencer to the datapath
  typedef struct packed {
    logic             capture;
    logic             finalByte;
    logic [SEL_W-1:0] byteSel;
  } ctlStrobe_t;

  typedef struct packed {
    logic copyAll;
    logic noBcast;
    logic ucEn;
    logic mcEn;
  } filtMode_t;
endpackage

// File: rtl/hf_ctrl.sv
module hf_ctrl
  import hf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       frameStart,
  output ctlStrobe_t strobe
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(ADDR_BYTES - 1);
  localparam logic [SEL_W-1:0] DONE_SEL = SEL_W'(ADDR_BYTES);

  logic [SEL_W-1:0] cntQ;
  logic             inField;

  // cntQ holds the index of the next byte; DONE_SEL means the field is complete
  assign inField = (cntQ != DONE_SEL);

  always_comb begin
    strobe.byteSel   = frameStart ? '0 : cntQ;
    strobe.capture   = byteValid && (frameStart || inField);
    strobe.finalByte = strobe.capture && (strobe.byteSel == LAST_SEL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cntQ <= DONE_SEL;
    else if (strobe.capture)
      cntQ <= strobe.byteSel + SEL_W'(1);
  end
endmodule

// File: rtl/hf_hash_fold.sv
module hf_hash_fold
  import hf_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  output logic [HASH_BITS-1:0] index
);
  function automatic logic foldTap(input logic [ADDR_W-1:0] a, input int n);
    logic r;
    r = 1'b0;
    for (int k = n; k < ADDR_W; k += HASH_BITS)
      r ^= a[k];
    return r;
  endfunction

  for (genvar n = 0; n < HASH_BITS; n++) begin : g_tap
    assign index[n] = foldTap(addr, n);
  end
endmodule

// File: rtl/hf_datapath.sv
module hf_datapath
  import hf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [BYTE_W-1:0]    byteIn,
  input  filtMode_t            modeCfg,
  input  logic [HALF_W-1:0]    hashLo,
  input  logic [HALF_W-1:0]    hashHi,
  input  logic [STA_LO_W-1:0]  stationLo,
  input  logic [STA_HI_W-1:0]  stationHi,
  output logic                 decValidQ,
  output logic                 acceptQ,
  output logic [HASH_BITS-1:0] hashIdxQ,
  output logic                 hashHitQ,
  output logic                 exactHitQ,
  output logic                 bcastQ
);
  localparam int HELD = ADDR_BYTES - 1;

  logic [BYTE_W-1:0]    laneQ [HELD];
  logic [ADDR_W-1:0]    addrFull;
  logic [HASH_BITS-1:0] foldIdx;
  logic [HASH_SIZE-1:0] hashTable;
  logic                 tableBit, groupBit, isBcast, mcHit, ucHit;
  logic                 hashHit, exactHit, blocked, acceptNow;

  // earlier bytes are held in lanes; the last byte is used straight from the input
  for (genvar i = 0; i < HELD; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneQ[i] <= '0;
      else if (strobe.capture && strobe.byteSel == SEL_W'(i))
        laneQ[i] <= byteIn;
    end
    assign addrFull[i*BYTE_W +: BYTE_W] = laneQ[i];
  end
  assign addrFull[HELD*BYTE_W +: BYTE_W] = byteIn;

  hf_hash_fold u_fold (
    .addr  (addrFull),
    .index (foldIdx)
  );

  assign hashTable = {hashHi, hashLo};

  always_comb begin
    tableBit  = hashTable[foldIdx];
    groupBit  = addrFull[0];
    isBcast   = &addrFull;
    mcHit     = modeCfg.mcEn && groupBit && tableBit;
    ucHit     = modeCfg.ucEn && !groupBit && tableBit;
    hashHit   = mcHit || ucHit;
    exactHit  = (addrFull == {stationHi, stationLo});
    blocked   = isBcast && modeCfg.noBcast;
    acceptNow = modeCfg.copyAll || (!blocked && (exactHit || isBcast || hashHit));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValidQ <= 1'b0;
      acceptQ   <= 1'b0;
      hashIdxQ  <= '0;
      hashHitQ  <= 1'b0;
      exactHitQ <= 1'b0;
      bcastQ    <= 1'b0;
    end else if (strobe.finalByte) begin
      decValidQ <= 1'b1;
      acceptQ   <= acceptNow;
      hashIdxQ  <= foldIdx;
      hashHitQ  <= hashHit;
      exactHitQ <= exactHit;
      bcastQ    <= isBcast;
    end else begin
      decValidQ <= 1'b0;
      acceptQ   <= 1'b0;
      hashIdxQ  <= '0;
      hashHitQ  <= 1'b0;
      exactHitQ <= 1'b0;
      bcastQ    <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter
  import hf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 byteValid,
  input  logic                 frameStart,
  input  logic [BYTE_W-1:0]    byteIn,
  input  logic                 copyAll,
  input  logic                 noBroadcast,
  input  logic                 ucHashEn,
  input  logic                 mcHashEn,
  input  logic [HALF_W-1:0]    hashLo,
  input  logic [HALF_W-1:0]    hashHi,
  input  logic [STA_LO_W-1:0]  stationLo,
  input  logic [STA_HI_W-1:0]  stationHi,
  output logic                 decisionValid,
  output logic                 accept,
  output logic [HASH_BITS-1:0] hashIndex,
  output logic                 hashHit,
  output logic                 exactHit,
  output logic                 broadcastSeen
);
  ctlStrobe_t strobe;
  filtMode_t  modeCfg;

  assign modeCfg.copyAll = copyAll;
  assign modeCfg.noBcast = noBroadcast;
  assign modeCfg.ucEn    = ucHashEn;
  assign modeCfg.mcEn    = mcHashEn;

  hf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .frameStart (frameStart),
    .strobe     (strobe)
  );

  hf_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteIn    (byteIn),
    .modeCfg   (modeCfg),
    .hashLo    (hashLo),
    .hashHi    (hashHi),
    .stationLo (stationLo),
    .stationHi (stationHi),
    .decValidQ (decisionValid),
    .acceptQ   (accept),
    .hashIdxQ  (hashIndex),
    .hashHitQ  (hashHit),
    .exactHitQ (exactHit),
    .bcastQ    (broadcastSeen)
  );
endmodule

// File: rtl/hf_checker.sv
module hf_checker
  import hf_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 byteValid,
  input logic                 copyAll,
  input logic                 noBroadcast,
  input logic                 decisionValid,
  input logic                 accept,
  input logic [HASH_BITS-1:0] hashIndex,
  input logic                 hashHit,
  input logic                 exactHit,
  input logic                 broadcastSeen
);
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid);

  p_after_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |-> $past(byteValid));

  p_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !decisionValid |-> (!accept && !hashHit && !exactHit && !broadcastSeen && hashIndex == '0));

  p_copy_all_r10: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && $past(copyAll)) |-> accept);

  p_no_bcast_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && broadcastSeen && $past(noBroadcast) && !$past(copyAll)) |-> !accept);

  p_exact_r8: assert property (@(posedge clk) disable iff (!rstN)
    (exactHit && !broadcastSeen) |-> accept);

  p_hash_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hashHit && !broadcastSeen) |-> accept);
endmodule

bind addr_hash_filter hf_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .byteValid     (byteValid),
  .copyAll       (copyAll),
  .noBroadcast   (noBroadcast),
  .decisionValid (decisionValid),
  .accept        (accept),
  .hashIndex     (hashIndex),
  .hashHit       (hashHit),
  .exactHit      (exactHit),
  .broadcastSeen (broadcastSeen)
);

// File: tb/addr_hash_filter_tb.sv
module addr_hash_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0, frameStart = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        copyAll = 1'b0, noBroadcast = 1'b0, ucHashEn = 1'b0, mcHashEn = 1'b0;
  logic [63:0] hashTab = '0;
  logic [47:0] station = '0;
  logic        decisionValid, accept, hashHit, exactHit, broadcastSeen;
  logic [5:0]  hashIndex;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [9:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  addr_hash_filter u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameStart(frameStart), .byteIn(byteIn),
    .copyAll(copyAll), .noBroadcast(noBroadcast), .ucHashEn(ucHashEn), .mcHashEn(mcHashEn),
    .hashLo(hashTab[31:0]), .hashHi(hashTab[63:32]),
    .stationLo(station[31:0]), .stationHi(station[47:32]),
    .decisionValid(decisionValid), .accept(accept), .hashIndex(hashIndex),
    .hashHit(hashHit), .exactHit(exactHit), .broadcastSeen(broadcastSeen)
  );

  // expected {accept, hashHit, exactHit, broadcast, index[5:0]} from R3..R10
  function automatic logic [9:0] predict(input logic [47:0] a);
    logic [5:0] idx;
    logic hh, ex, bc, acc, tb;
    for (int n = 0; n < 6; n++) begin
      idx[n] = 1'b0;
      for (int k = 0; k < 8; k++) idx[n] = idx[n] ^ a[6*k + n];
    end
    tb  = hashTab[idx];
    hh  = tb && ((mcHashEn && a[0]) || (ucHashEn && !a[0]));
    ex  = (a == station);
    bc  = (a == 48'hFFFF_FFFF_FFFF);
    acc = copyAll || (!(bc && noBroadcast) && (ex || bc || hh));
    return {acc, hh, ex, bc, idx};
  endfunction

  function automatic logic [5:0] foldOf(input logic [47:0] a);
    logic [9:0] p;
    p = predict(a);
    return p[5:0];
  endfunction

  // driver: pushes the expectation at the sixth byte, then drives the bytes
  task automatic sendFrame(input logic [47:0] a, input string tag, input bit gaps);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      byteValid  = 1'b1;
      frameStart = (i == 0);
      byteIn     = a[8*i +: 8];
      if (i == 5) begin
        expQ.push_back(predict(a));
        tagQ.push_back(tag);
      end
      if (gaps && i < 5) begin
        @(posedge clk); #1;
        byteValid = 1'b0; frameStart = 1'b0; byteIn = 8'hA5;
      end
    end
    @(posedge clk); #1;
    byteValid = 1'b0; frameStart = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compare each decision against the scoreboard
  always @(negedge clk) begin
    if (rstN && decisionValid) begin
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R11 unexpected decision: actual valid=1 expected valid=0");
      end else begin
        logic [9:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({accept, hashHit, exactHit, broadcastSeen, hashIndex} !== e) begin
          miscompares++;
          $display("FAIL %s: actual acc=%b hh=%b ex=%b bc=%b idx=%0d expected acc=%b hh=%b ex=%b bc=%b idx=%0d",
                   t, accept, hashHit, exactHit, broadcastSeen, hashIndex,
                   e[9], e[8], e[7], e[6], e[5:0]);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog: actual run hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    // R1: reset state
    repeat (2) @(negedge clk);
    vectors++;
    if (decisionValid !== 1'b0 || accept !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 in reset: actual valid=%b acc=%b expected 0 0", decisionValid, accept);
    end
    @(posedge clk); #1 rstN = 1'b1;
    idle(3);
    vectors++;
    if (decisionValid !== 1'b0 || accept !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 after reset: actual valid=%b acc=%b expected 0 0", decisionValid, accept);
    end

    // R3: single-bit addresses map to known index bits
    sendFrame(48'h8000_0000_0000, "R3 bit47", 0);
    sendFrame(48'h0000_0000_0040, "R3 bit6", 0);
    sendFrame(48'h0123_4567_89AB, "R3 mixed", 0);

    // R5: multicast hash hit / miss
    mcHashEn = 1'b1;
    a = 48'h0000_3300_5E01;
    hashTab = 64'd1 << foldOf(a);
    sendFrame(a, "R5 mc hit", 0);
    hashTab = ~(64'd1 << foldOf(a));
    sendFrame(a, "R5 mc bit clear", 0);
    hashTab = '1;
    sendFrame(48'h1234_5678_9A03, "R5 all ones mc", 0);
    // R7: unicast address with only mc enable
    sendFrame(48'h1234_5678_9A02, "R7 uc with mc only", 0);
    // R6: unicast hit, and R7 multicast with only uc enable
    mcHashEn = 1'b0; ucHashEn = 1'b1;
    sendFrame(48'h1234_5678_9A02, "R6 uc hit", 0);
    sendFrame(48'h1234_5678_9A03, "R7 mc with uc only", 0);
    // R4: halves of the table
    ucHashEn = 1'b0; mcHashEn = 1'b1;
    hashTab = 64'hFFFF_FFFF_0000_0000;
    sendFrame(48'h8000_0000_0001, "R4 high half", 0);
    sendFrame(48'h0000_0000_0001, "R4 low half", 0);
    hashTab = 64'h0000_0000_FFFF_FFFF;
    sendFrame(48'h8000_0000_0001, "R4 high clear", 0);
    sendFrame(48'h0000_0000_0001, "R4 low set", 0);
    mcHashEn = 1'b0; hashTab = '0;

    // R8: exact match and near miss in last byte
    station = 48'hA1B2_C3D4_E5F6;
    sendFrame(48'hA1B2_C3D4_E5F6, "R8 exact", 0);
    sendFrame(48'hA0B2_C3D4_E5F6, "R8 last byte differs", 0);
    sendFrame(48'hA1B2_C3D4_E5F7, "R8 first byte differs", 0);

    // R9: broadcast
    sendFrame(48'hFFFF_FFFF_FFFF, "R9 bcast allowed", 0);
    noBroadcast = 1'b1; mcHashEn = 1'b1; hashTab = '1;
    sendFrame(48'hFFFF_FFFF_FFFF, "R9 bcast blocked over hash", 0);
    station = 48'hFFFF_FFFF_FFFF;
    sendFrame(48'hFFFF_FFFF_FFFF, "R9 bcast blocked over exact", 0);
    // R10: copy-all
    copyAll = 1'b1;
    sendFrame(48'hFFFF_FFFF_FFFF, "R10 copy-all bcast", 0);
    mcHashEn = 1'b0; hashTab = '0;
    sendFrame(48'h0BAD_CAFE_0002, "R10 copy-all uc", 0);
    copyAll = 1'b0; noBroadcast = 1'b0; station = 48'hA1B2_C3D4_E5F6;

    // R11: idle gaps, trailing bytes, restart
    sendFrame(48'hA1B2_C3D4_E5F6, "R11 gaps", 1);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 byteValid = 1'b1; frameStart = 1'b0; byteIn = 8'(i);
    end
    @(posedge clk); #1 byteValid = 1'b0;
    idle(2);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 byteValid = 1'b1; frameStart = (i == 0); byteIn = 8'h11;
    end
    sendFrame(48'hA1B2_C3D4_E5F6, "R11 restart", 0);

    // R12: configuration changed right after the sixth byte
    copyAll = 1'b0;
    sendFrame(48'h0000_0000_0100, "R12 late copy-all", 0);
    copyAll = 1'b1;
    idle(2);
    sendFrame(48'h0000_0000_0100, "R12 copy-all set", 0);
    copyAll = 1'b0; station = 48'h0000_0000_0100;
    idle(2);

    // mixed random frames (R2, R3, R5, R6, R9)
    for (int i = 0; i < 40; i++) begin
      hashTab = {$urandom, $urandom};
      {copyAll, noBroadcast, ucHashEn, mcHashEn} = 4'($urandom);
      if (i % 8 == 0) a = 48'hFFFF_FFFF_FFFF;
      else if (i % 8 == 1) a = station;
      else a = {16'($urandom), $urandom};
      sendFrame(a, "R2 random frame", i % 3 == 0);
    end

    idle(4);
    vectors++;
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL R2 missing decisions: actual %0d pending expected 0", expQ.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule